// File: doc/BRIEF.md
# Accelerator Handoff and Shared Data-Memory Controller

This block sits between an in-order processor pipeline and a tightly coupled accelerator that works in the same address space and on the same data memory. It watches the instruction in decode for two custom instructions. One transfers execution to the accelerator. The other sets the address where the processor continues once the accelerator is finished. No data is copied at a handoff: the block stalls the pipeline, passes the accelerator one start pulse and an address computed from a register and an offset, and gives the single data-memory port to the accelerator until the accelerator reports that it is done.

When the accelerator finishes, the memory port goes back to the processor in the next cycle. In that same cycle the stall drops and a one-cycle resume indication carries the continuation address to the fetch logic. The continuation address is the one set by an earlier return-marker instruction if one is pending, and otherwise the address after the handoff instruction. A custom instruction that reaches decode while a handoff is still in progress is held there until the controller is idle again.

Top module: `acc_handoff_ctrl`

## Requirements
- R1: Bits 6:0 of the instruction select the operation. Opcode 0001011 is branch-to-accelerator and opcode 0101011 is return-marker. Any other opcode causes no stall, no start and no hold. Bits 14:12 and bits 11:7 do not affect either custom instruction.
- R2: The address handed to the accelerator (acc_base) equals the rs1 value plus the sign-extended 12-bit offset from bits 31:20. It stays unchanged for the whole handoff.
- R3: A branch-to-accelerator accepted while idle causes, in the next cycle, a one-cycle acc_start pulse, and pipe_stall rises in that same cycle.
- R4: pipe_stall stays high through the cycle in which acc_done is high and is low in the cycle after it.
- R5: While pipe_stall is high, the memory address, write data and write enable come from the accelerator side. A processor write in that time has no effect on memory.
- R6: While pipe_stall is low, the memory address, write data and write enable come from the processor side.
- R7: Memory read data reaches both the processor and the accelerator read ports in every state.
- R8: In the cycle after acc_done, resume_valid is high for exactly one cycle and resume_pc gives the continuation address.
- R9: A return-marker decoded while idle stores rs1 plus the sign-extended offset as the pending continuation address, with no stall. The next handoff uses it and clears it. With none pending, the continuation address is the handoff instruction's pc plus 4.
- R10: A custom instruction presented while a handoff is in progress, including the resume cycle, raises dec_hold and has no effect. In particular, it changes neither acc_base nor the pending continuation address.
- R11: After reset the controller is idle: pipe_stall, acc_start, resume_valid and dec_hold are low and no continuation address is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode stage holds a valid instruction |
| dec_instr | input | 32 | Instruction word in decode |
| dec_rs1 | input | XLEN | Value of the instruction's base register |
| dec_pc | input | XLEN | Address of the instruction in decode |
| dec_hold | output | 1 | Custom instruction must wait in decode |
| pipe_stall | output | 1 | Stall to the processor control path |
| resume_valid | output | 1 | One-cycle continuation indication |
| resume_pc | output | XLEN | Continuation address |
| cpu_addr | input | XLEN | Processor memory address |
| cpu_wdata | input | DW | Processor write data |
| cpu_we | input | 1 | Processor write enable |
| cpu_rdata | output | DW | Read data to the processor |
| acc_start | output | 1 | One-cycle start to the accelerator |
| acc_base | output | XLEN | Address handed to the accelerator |
| acc_addr | input | XLEN | Accelerator memory address |
| acc_wdata | input | DW | Accelerator write data |
| acc_we | input | 1 | Accelerator write enable |
| acc_rdata | output | DW | Read data to the accelerator |
| acc_done | input | 1 | Accelerator completion pulse |
| mem_addr | output | XLEN | Shared memory address |
| mem_wdata | output | DW | Shared memory write data |
| mem_we | output | 1 | Shared memory write enable |
| mem_rdata | input | DW | Shared memory read data |

## Verification
The assertions assume that the accelerator raises acc_done for a single cycle, and only after it has received a start pulse. A done pulse outside a handoff would otherwise break the stall-until-done property. The assertions also assume the accelerator keeps its write enable low until it has been started. The bench's memory-walking stub keeps to this. It reacts only to acc_start, performs a fixed number of word writes from the handed-over base, and then pulses done once. The decode stimulus drops dec_valid after each instruction is accepted, and it raises dec_valid during a handoff only for the deliberate hold probes.

// File: rtl/acc_handoff_pkg.sv
package acc_handoff_pkg;

    localparam int INSTR_W = 32;
    localparam int OFS_W   = 12;

    localparam logic [6:0] OPC_TO_AUX = 7'b0001011;
    localparam logic [6:0] OPC_TO_PRI = 7'b0101011;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN    = 2'd2,
        ST_RETURN = 2'd3
    } hand_state_e;

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        logic [6:0]       opc;
    } instr_view_t;

    function automatic instr_view_t view_instr(input logic [INSTR_W-1:0] w);
        instr_view_t v;
        v.ofs = w[31:20];
        v.opc = w[6:0];
        return v;
    endfunction

    function automatic logic state_owns_mem(input hand_state_e s);
        return (s == ST_LAUNCH) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/acc_handoff_decode.sv
module acc_handoff_decode
    import acc_handoff_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                dec_valid,
    input  logic [INSTR_W-1:0]  dec_instr,
    input  logic [XLEN-1:0]     dec_rs1,
    output logic                go_aux,
    output logic                go_pri,
    output logic [XLEN-1:0]     target
);
    localparam int EXT_W = XLEN - OFS_W;

    instr_view_t view;
    logic        unused_fields;
    logic [XLEN-1:0] ofs_ext;

    assign view          = view_instr(dec_instr);
    assign unused_fields = ^dec_instr[19:7];

    assign go_aux  = dec_valid && (view.opc == OPC_TO_AUX);
    assign go_pri  = dec_valid && (view.opc == OPC_TO_PRI);
    assign ofs_ext = {{EXT_W{view.ofs[OFS_W-1]}}, view.ofs};
    assign target  = dec_rs1 + ofs_ext;

endmodule

// File: rtl/acc_handoff_fsm.sv
module acc_handoff_fsm
    import acc_handoff_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go_aux,
    input  logic            go_pri,
    input  logic [XLEN-1:0] target,
    input  logic [XLEN-1:0] dec_pc,
    input  logic            acc_done,
    output logic            acc_owns,
    output logic            acc_start,
    output logic [XLEN-1:0] acc_base,
    output logic            resume_valid,
    output logic [XLEN-1:0] resume_pc,
    output logic            dec_hold
);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    hand_state_e     state_q;
    logic [XLEN-1:0] base_q;
    logic [XLEN-1:0] resume_q;
    logic [XLEN-1:0] pend_q;
    logic            pend_vld_q;
    logic            idle;

    assign idle = (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            base_q     <= '0;
            resume_q   <= '0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go_aux) begin
                        base_q     <= target;
                        resume_q   <= pend_vld_q ? pend_q : (dec_pc + PC_STEP);
                        pend_vld_q <= 1'b0;
                        state_q    <= ST_LAUNCH;
                    end else if (go_pri) begin
                        pend_q     <= target;
                        pend_vld_q <= 1'b1;
                    end
                end
                ST_LAUNCH: state_q <= ST_RUN;
                ST_RUN: begin
                    if (acc_done) state_q <= ST_RETURN;
                end
                ST_RETURN: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign acc_owns     = state_owns_mem(state_q);
    assign acc_start    = (state_q == ST_LAUNCH);
    assign acc_base     = base_q;
    assign resume_valid = (state_q == ST_RETURN);
    assign resume_pc    = resume_q;
    assign dec_hold     = (go_aux || go_pri) && !idle;

endmodule

// File: rtl/acc_handoff_memmux.sv
module acc_handoff_memmux #(
    parameter int XLEN = 32,
    parameter int DW   = 32
) (
    input  logic            acc_owns,
    input  logic [XLEN-1:0] cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    input  logic            cpu_we,
    input  logic [XLEN-1:0] acc_addr,
    input  logic [DW-1:0]   acc_wdata,
    input  logic            acc_we,
    input  logic [DW-1:0]   mem_rdata,
    output logic [XLEN-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_we,
    output logic [DW-1:0]   cpu_rdata,
    output logic [DW-1:0]   acc_rdata
);
    always_comb begin
        if (acc_owns) begin
            mem_addr  = acc_addr;
            mem_wdata = acc_wdata;
            mem_we    = acc_we;
        end else begin
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
            mem_we    = cpu_we;
        end
    end

    assign cpu_rdata = mem_rdata;
    assign acc_rdata = mem_rdata;

endmodule

// File: rtl/acc_handoff_ctrl.sv
module acc_handoff_ctrl
    import acc_handoff_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int DW   = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dec_valid,
    input  logic [INSTR_W-1:0]  dec_instr,
    input  logic [XLEN-1:0]     dec_rs1,
    input  logic [XLEN-1:0]     dec_pc,
    output logic                dec_hold,
    output logic                pipe_stall,
    output logic                resume_valid,
    output logic [XLEN-1:0]     resume_pc,
    input  logic [XLEN-1:0]     cpu_addr,
    input  logic [DW-1:0]       cpu_wdata,
    input  logic                cpu_we,
    output logic [DW-1:0]       cpu_rdata,
    output logic                acc_start,
    output logic [XLEN-1:0]     acc_base,
    input  logic [XLEN-1:0]     acc_addr,
    input  logic [DW-1:0]       acc_wdata,
    input  logic                acc_we,
    output logic [DW-1:0]       acc_rdata,
    input  logic                acc_done,
    output logic [XLEN-1:0]     mem_addr,
    output logic [DW-1:0]       mem_wdata,
    output logic                mem_we,
    input  logic [DW-1:0]       mem_rdata
);
    logic            go_aux;
    logic            go_pri;
    logic [XLEN-1:0] target;
    logic            acc_owns;

    acc_handoff_decode #(.XLEN(XLEN)) u_decode (
        .dec_valid (dec_valid),
        .dec_instr (dec_instr),
        .dec_rs1   (dec_rs1),
        .go_aux    (go_aux),
        .go_pri    (go_pri),
        .target    (target)
    );

    acc_handoff_fsm #(.XLEN(XLEN)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .go_aux       (go_aux),
        .go_pri       (go_pri),
        .target       (target),
        .dec_pc       (dec_pc),
        .acc_done     (acc_done),
        .acc_owns     (acc_owns),
        .acc_start    (acc_start),
        .acc_base     (acc_base),
        .resume_valid (resume_valid),
        .resume_pc    (resume_pc),
        .dec_hold     (dec_hold)
    );

    acc_handoff_memmux #(.XLEN(XLEN), .DW(DW)) u_memmux (
        .acc_owns  (acc_owns),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_we    (acc_we),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .cpu_rdata (cpu_rdata),
        .acc_rdata (acc_rdata)
    );

    assign pipe_stall = acc_owns;

endmodule

// File: rtl/acc_handoff_checker.sv
module acc_handoff_checker #(
    parameter int XLEN = 32,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            dec_valid,
    input logic            dec_hold,
    input logic            pipe_stall,
    input logic            resume_valid,
    input logic [XLEN-1:0] cpu_addr,
    input logic [DW-1:0]   cpu_wdata,
    input logic            cpu_we,
    input logic            acc_start,
    input logic [XLEN-1:0] acc_base,
    input logic [XLEN-1:0] acc_addr,
    input logic [DW-1:0]   acc_wdata,
    input logic            acc_we,
    input logic            acc_done,
    input logic [XLEN-1:0] mem_addr,
    input logic [DW-1:0]   mem_wdata,
    input logic            mem_we
);
    p_stall_port_acc_r5: assert property (@(posedge clk) disable iff (rst)
        pipe_stall |-> (mem_addr == acc_addr && mem_wdata == acc_wdata && mem_we == acc_we));

    p_free_port_cpu_r6: assert property (@(posedge clk) disable iff (rst)
        !pipe_stall |-> (mem_addr == cpu_addr && mem_wdata == cpu_wdata && mem_we == cpu_we));

    p_start_single_r3: assert property (@(posedge clk) disable iff (rst)
        acc_start |=> !acc_start);

    p_start_with_stall_r3: assert property (@(posedge clk) disable iff (rst)
        acc_start |-> pipe_stall);

    p_stall_rise_on_start_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pipe_stall) |-> acc_start);

    p_stall_until_done_r4: assert property (@(posedge clk) disable iff (rst)
        (pipe_stall && !acc_done) |=> pipe_stall);

    p_release_after_done_r4: assert property (@(posedge clk) disable iff (rst)
        (pipe_stall && !acc_start && acc_done) |=> (!pipe_stall && resume_valid));

    p_resume_single_r8: assert property (@(posedge clk) disable iff (rst)
        resume_valid |=> !resume_valid);

    p_base_steady_r2: assert property (@(posedge clk) disable iff (rst)
        (pipe_stall && !acc_start) |-> $stable(acc_base));

    p_hold_has_instr_r10: assert property (@(posedge clk) disable iff (rst)
        dec_hold |-> dec_valid);

endmodule

bind acc_handoff_ctrl acc_handoff_checker #(.XLEN(XLEN), .DW(DW)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .dec_valid    (dec_valid),
    .dec_hold     (dec_hold),
    .pipe_stall   (pipe_stall),
    .resume_valid (resume_valid),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_we       (cpu_we),
    .acc_start    (acc_start),
    .acc_base     (acc_base),
    .acc_addr     (acc_addr),
    .acc_wdata    (acc_wdata),
    .acc_we       (acc_we),
    .acc_done     (acc_done),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_we       (mem_we)
);

// File: tb/acc_handoff_ctrl_bench.sv
module acc_handoff_ctrl_bench;

    localparam int XLEN  = 32;
    localparam int DW    = 32;
    localparam int WORDS = 4;
    localparam logic [6:0] OP_AUX = 7'b0001011;
    localparam logic [6:0] OP_PRI = 7'b0101011;
    localparam logic [6:0] OP_ALU = 7'b0010011;
    localparam logic [31:0] GUARD_ADDR = 32'h0000_00F0;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            dec_valid = 1'b0;
    logic [31:0]     dec_instr = '0;
    logic [XLEN-1:0] dec_rs1 = '0;
    logic [XLEN-1:0] dec_pc = '0;
    logic            dec_hold;
    logic            pipe_stall;
    logic            resume_valid;
    logic [XLEN-1:0] resume_pc;
    logic [XLEN-1:0] cpu_addr = '0;
    logic [DW-1:0]   cpu_wdata = '0;
    logic            cpu_we = 1'b0;
    logic [DW-1:0]   cpu_rdata;
    logic            acc_start;
    logic [XLEN-1:0] acc_base;
    logic [XLEN-1:0] acc_addr;
    logic [DW-1:0]   acc_wdata;
    logic            acc_we;
    logic [DW-1:0]   acc_rdata;
    logic            acc_done;
    logic [XLEN-1:0] mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic            mem_we;
    logic [DW-1:0]   mem_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    acc_handoff_ctrl #(.XLEN(XLEN), .DW(DW)) u_acc_handoff_ctrl (
        .clk(clk), .rst(rst),
        .dec_valid(dec_valid), .dec_instr(dec_instr), .dec_rs1(dec_rs1), .dec_pc(dec_pc),
        .dec_hold(dec_hold), .pipe_stall(pipe_stall),
        .resume_valid(resume_valid), .resume_pc(resume_pc),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_rdata(cpu_rdata),
        .acc_start(acc_start), .acc_base(acc_base),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_we(acc_we), .acc_rdata(acc_rdata),
        .acc_done(acc_done),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    // shared data memory model: 64 words, word index from address bits 7:2
    logic [DW-1:0] bmem [64];
    assign mem_rdata = bmem[mem_addr[7:2]];
    always_ff @(posedge clk) begin
        if (mem_we) bmem[mem_addr[7:2]] <= mem_wdata;
    end

    function automatic logic [DW-1:0] stub_word(input logic [31:0] base, input int k);
        return {8'hA5, base[23:0]} + DW'(k);
    endfunction

    // accelerator stub: walks WORDS words upward from the handed base, then pulses done
    logic        stub_busy = 1'b0;
    int          stub_k = 0;
    logic [31:0] stub_base = '0;
    initial begin
        acc_addr  = '0;
        acc_wdata = '0;
        acc_we    = 1'b0;
        acc_done  = 1'b0;
    end
    always @(posedge clk) begin
        acc_done <= 1'b0;
        if (acc_start && !stub_busy) begin
            stub_busy <= 1'b1;
            stub_base <= acc_base;
            stub_k    <= 0;
            acc_we    <= 1'b0;
        end else if (stub_busy) begin
            if (stub_k < WORDS) begin
                acc_addr  <= stub_base + 32'(4 * stub_k);
                acc_wdata <= stub_word(stub_base, stub_k);
                acc_we    <= 1'b1;
                stub_k    <= stub_k + 1;
            end else begin
                acc_we    <= 1'b0;
                acc_done  <= 1'b1;
                stub_busy <= 1'b0;
            end
        end else begin
            acc_we <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic present(input logic [6:0] opc, input logic [11:0] imm, input logic [31:0] rs1,
                           input logic [31:0] pc, input logic [2:0] f3, input logic [4:0] junk);
        dec_instr = {imm, 5'd3, f3, junk, opc};
        dec_rs1   = rs1;
        dec_pc    = pc;
        dec_valid = 1'b1;
    endtask

    // one full handoff; optionally probes the hold behaviour while busy
    task automatic do_handoff(input logic [11:0] imm, input logic [31:0] rs1, input logic [31:0] pc,
                              input logic [2:0] f3, input logic [4:0] junk,
                              input logic [31:0] exp_base, input logic [31:0] exp_resume,
                              input bit probe);
        @(negedge clk);
        present(OP_AUX, imm, rs1, pc, f3, junk);
        #1 chk(dec_hold == 1'b0, "R10 idle accept no hold", 32'(dec_hold), 32'd0);
        @(negedge clk);
        dec_valid = 1'b0;
        cpu_addr  = GUARD_ADDR;
        cpu_wdata = 32'hDEAD_BEEF;
        cpu_we    = 1'b1;
        chk(acc_start == 1'b1, "R3 start pulse", 32'(acc_start), 32'd1);
        chk(pipe_stall == 1'b1, "R3 stall with start", 32'(pipe_stall), 32'd1);
        chk(acc_base == exp_base, "R2 handoff address", acc_base, exp_base);
        if (probe) begin
            @(negedge clk);
            present(OP_AUX, 12'h004, 32'h0000_0080, 32'h700, 3'd0, 5'd0);
            #1 chk(dec_hold == 1'b1, "R10 hold branch while busy", 32'(dec_hold), 32'd1);
            @(negedge clk);
            present(OP_PRI, 12'h000, 32'h0000_0999, 32'h704, 3'd0, 5'd0);
            #1 chk(dec_hold == 1'b1, "R10 hold marker while busy", 32'(dec_hold), 32'd1);
            chk(acc_base == exp_base, "R10 base unchanged", acc_base, exp_base);
            @(negedge clk);
            dec_valid = 1'b0;
        end
        while (!acc_done) @(negedge clk);
        chk(pipe_stall == 1'b1, "R4 stall in done cycle", 32'(pipe_stall), 32'd1);
        chk(mem_addr == acc_addr, "R5 address from accelerator", mem_addr, acc_addr);
        chk(acc_rdata == bmem[mem_addr[7:2]], "R7 read data to accelerator", acc_rdata, bmem[mem_addr[7:2]]);
        chk(cpu_rdata == bmem[mem_addr[7:2]], "R7 read data to processor", cpu_rdata, bmem[mem_addr[7:2]]);
        cpu_we = 1'b0;
        @(negedge clk);
        chk(pipe_stall == 1'b0, "R4 stall released", 32'(pipe_stall), 32'd0);
        chk(resume_valid == 1'b1, "R8 resume valid", 32'(resume_valid), 32'd1);
        chk(resume_pc == exp_resume, "R8 resume address", resume_pc, exp_resume);
        chk(mem_addr == cpu_addr, "R6 port back to processor", mem_addr, cpu_addr);
        @(negedge clk);
        chk(resume_valid == 1'b0, "R8 resume single cycle", 32'(resume_valid), 32'd0);
        for (int k = 0; k < WORDS; k++) begin
            logic [31:0] a;
            a = exp_base + 32'(4 * k);
            chk(bmem[a[7:2]] == stub_word(exp_base, k), "R5 accelerator write landed",
                bmem[a[7:2]], stub_word(exp_base, k));
        end
        chk(bmem[GUARD_ADDR[7:2]] == 32'h0000_1111, "R5 processor write ignored while stalled",
            bmem[GUARD_ADDR[7:2]], 32'h0000_1111);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pipe_stall == 1'b0, "R11 reset stall", 32'(pipe_stall), 32'd0);
        chk(acc_start == 1'b0, "R11 reset start", 32'(acc_start), 32'd0);
        chk(resume_valid == 1'b0, "R11 reset resume", 32'(resume_valid), 32'd0);
        chk(dec_hold == 1'b0, "R11 reset hold", 32'(dec_hold), 32'd0);
    endtask

    task automatic t_cpu_side();
        @(negedge clk);
        cpu_addr  = GUARD_ADDR;
        cpu_wdata = 32'h0000_1111;
        cpu_we    = 1'b1;
        #1 chk(mem_addr == GUARD_ADDR && mem_we == 1'b1, "R6 processor drives port", mem_addr, GUARD_ADDR);
        @(negedge clk);
        cpu_we = 1'b0;
        #1 chk(cpu_rdata == 32'h0000_1111, "R6 processor write stored", cpu_rdata, 32'h0000_1111);
        chk(acc_rdata == 32'h0000_1111, "R7 read data shared while idle", acc_rdata, 32'h0000_1111);
    endtask

    task automatic t_other_opcode();
        @(negedge clk);
        present(OP_ALU, 12'h010, 32'h40, 32'h100, 3'd0, 5'd1);
        #1 chk(dec_hold == 1'b0, "R1 other opcode no hold", 32'(dec_hold), 32'd0);
        @(negedge clk);
        dec_valid = 1'b0;
        chk(pipe_stall == 1'b0, "R1 other opcode no stall", 32'(pipe_stall), 32'd0);
        chk(acc_start == 1'b0, "R1 other opcode no start", 32'(acc_start), 32'd0);
        @(negedge clk);
        chk(pipe_stall == 1'b0, "R1 other opcode still idle", 32'(pipe_stall), 32'd0);
    endtask

    task automatic t_marker_then_handoff();
        @(negedge clk);
        present(OP_PRI, 12'h020, 32'h300, 32'h400, 3'd2, 5'd0);
        @(negedge clk);
        dec_valid = 1'b0;
        chk(pipe_stall == 1'b0, "R9 marker no stall", 32'(pipe_stall), 32'd0);
        chk(acc_start == 1'b0, "R9 marker no start", 32'(acc_start), 32'd0);
        do_handoff(12'h008, 32'h0000_0020, 32'h500, 3'd0, 5'd0, 32'h28, 32'h320, 1'b0);
        do_handoff(12'h000, 32'h0000_0060, 32'h600, 3'd0, 5'd0, 32'h60, 32'h604, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_cpu_side();
        t_other_opcode();
        // R1 R2: width and unused fields set, positive offset
        do_handoff(12'h010, 32'h0000_0040, 32'h100, 3'd5, 5'h1f, 32'h50, 32'h104, 1'b0);
        // R2: negative offset
        do_handoff(12'hFC0, 32'h0000_0100, 32'h200, 3'd0, 5'd0, 32'hC0, 32'h204, 1'b0);
        t_marker_then_handoff();
        // R10: custom instructions while busy are held and leave no trace
        do_handoff(12'h004, 32'h0000_0090, 32'h800, 3'd0, 5'd0, 32'h94, 32'h804, 1'b1);
        do_handoff(12'h000, 32'h0000_00A0, 32'h900, 3'd0, 5'd0, 32'hA0, 32'h904, 1'b0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule